// File: doc/BRIEF.md
# Bit-Oriented Message Receiver

This block watches the serial data link of a line interface and picks out 16-bit bit-oriented message codewords. Each codeword opens with a run of eight ones. A zero follows, then a 6-bit code, then a closing zero. The receiver finds codeword boundaries from the eight-ones run. It keeps a sliding history of the last ten codewords and declares a code valid only when it repeats often enough. While valid, the code is held steady on the output.

Two alarms come out as one-cycle pulses. The first fires when a held code loses its majority. The second fires when the line carries no eight-ones run for too long. Both alarms, and all receive state, exist only while the enable input is high. Dropping the enable clears the history. The block sits behind a bit-rate strobe: it acts only on cycles where the strobe marks a fresh data bit.

Top module: `bitmsg_rx`

## Requirements
- R1: After reset, code_valid, msg_lost and sync_fault are low and code_out is zero.
- R2: A bit is accepted only on a cycle with enable and bit_valid both high. Ones are counted since the last zero or the last detected run. An accepted one that makes this count eight is a flag. When a flag is seen and no frame is being captured, the next eight accepted bits form a frame. In the frame, the first bit must be 0, the next six bits are the code with the most significant bit first, and the last bit must be 0.
- R3: When a frame completes and no code is valid, the new code becomes valid if at least 7 of the last 10 frames, including the new one, carry that code with correct framing. code_valid and code_out change in the cycle after the frame's final bit is accepted.
- R4: While code_valid stays high, code_out does not change.
- R5: At each completed frame while valid, the receiver checks the held code. If fewer than 7 of the last 10 frames match it, code_valid falls and msg_lost pulses for exactly one cycle, in the same cycle.
- R6: A frame whose first or last bit is 1 takes a slot in the 10-frame history but matches no code.
- R7: A counter of accepted bits restarts at every flag. If the 32nd accepted bit after the last restart is not itself a flag, sync_fault pulses for one cycle and the counter restarts. A flag on that bit wins, and no pulse is given.
- R8: While enable is low, the history, valid state and counters are cleared, and no pulse or valid code is output.
- R9: Cycles with bit_valid low change no state, whatever bit_data carries.
- R10: code_out is zero whenever code_valid is low.
- R11: A flag that completes on the final bit of a frame restarts the sync counter but does not start a new capture. A line of continuous ones therefore raises no sync_fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver enable; low clears all state |
| bit_valid | input | 1 | Strobe marking a new serial bit on bit_data |
| bit_data | input | 1 | Serial data bit |
| code_out | output | 6 | Currently valid code, zero when none |
| code_valid | output | 1 | A code is held as valid |
| msg_lost | output | 1 | One-cycle pulse when the valid state is left |
| sync_fault | output | 1 | One-cycle pulse when 32 bits pass without a flag |

## Verification
One bit can finish an eight-ones flag and also be the 32nd bit since the last flag. When that happens, the flag search and the sync window act in the same cycle. The bench provokes this by sending exactly 24 zeros after a flag and then eight ones. It expects no sync_fault, and it expects a new frame capture to begin. A second collision happens when an all-ones frame ends on a flag. Here the frame retirement and the flag detection coincide, and the bench checks that retirement happens without a new capture, using long runs of idle ones. A behavioural model compares every output on every clock, so an early or late pulse in either collision shows up as a miscompare.

// File: rtl/bitmsg_pkg.sv
package bitmsg_pkg;

    // Capture phase of the frame assembler
    typedef enum logic {
        CAP_HUNT = 1'b0,
        CAP_BODY = 1'b1
    } cap_phase_e;

endpackage

// File: rtl/bitmsg_flag_track.sv
// Finds eight-ones flags on the serial line and times the sync window.
module bitmsg_flag_track #(
    parameter int FLAG_LEN = 8,
    parameter int SYNC_WIN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_stb,
    input  logic bit_data,
    output logic flag_hit,
    output logic sync_err
);
    localparam int RUN_W = (FLAG_LEN > 1) ? $clog2(FLAG_LEN) : 1;
    localparam int WIN_W = (SYNC_WIN > 1) ? $clog2(SYNC_WIN) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FLAG_LEN - 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(SYNC_WIN - 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic [WIN_W-1:0] win;
        logic             err;
    } trk_state_t;

    trk_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.err  = 1'b0;
        flag_hit = 1'b0;
        if (!enable) begin
            s_d = '0;
        end else if (bit_stb) begin
            if (bit_data) begin
                if (s_q.run == RUN_LAST) begin
                    flag_hit = 1'b1;
                    s_d.run  = '0;
                end else begin
                    s_d.run = s_q.run + 1'b1;
                end
            end else begin
                s_d.run = '0;
            end

            if (flag_hit) begin
                s_d.win = '0;
            end else if (s_q.win == WIN_LAST) begin
                s_d.win = '0;
                s_d.err = 1'b1;
            end else begin
                s_d.win = s_q.win + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_err = s_q.err;

endmodule

// File: rtl/bitmsg_word_capture.sv
// Collects the frame that follows a flag and checks its zero framing.
module bitmsg_word_capture
    import bitmsg_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_stb,
    input  logic              bit_data,
    input  logic              flag_hit,
    output logic              word_stb,
    output logic              word_ok,
    output logic [CODE_W-1:0] word_code
);
    localparam int CAP_LEN = CODE_W + 2;
    localparam int CNT_W   = $clog2(CAP_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CAP_LEN - 1);

    typedef struct packed {
        cap_phase_e         phase;
        logic [CNT_W-1:0]   cnt;
        logic [CAP_LEN-2:0] sh;
    } cap_state_t;

    cap_state_t s_d, s_q;
    logic [CAP_LEN-1:0] frame;

    // first received bit lands at the top of the frame
    assign frame     = {s_q.sh, bit_data};
    assign word_ok   = !frame[CAP_LEN-1] && !frame[0];
    assign word_code = frame[CAP_LEN-2:1];

    always_comb begin
        s_d      = s_q;
        word_stb = 1'b0;
        if (!enable) begin
            s_d = '0;
        end else if (bit_stb) begin
            if (s_q.phase == CAP_BODY) begin
                s_d.sh = frame[CAP_LEN-2:0];
                if (s_q.cnt == CNT_LAST) begin
                    word_stb  = 1'b1;
                    s_d.phase = CAP_HUNT;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else if (flag_hit) begin
                s_d.phase = CAP_BODY;
                s_d.cnt   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/bitmsg_vote_filter.sv
// Sliding history of received frames and the majority decision.
module bitmsg_vote_filter #(
    parameter int CODE_W     = 6,
    parameter int HIST_DEPTH = 10,
    parameter int MATCH_MIN  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              word_stb,
    input  logic              word_ok,
    input  logic [CODE_W-1:0] word_code,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid,
    output logic              msg_lost
);
    localparam int CNT_W = $clog2(HIST_DEPTH + 1);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MATCH_MIN);

    typedef struct packed {
        logic              ok;
        logic [CODE_W-1:0] code;
    } slot_t;

    typedef struct packed {
        slot_t [HIST_DEPTH-1:0] hist;
        logic                   valid;
        logic [CODE_W-1:0]      held;
        logic                   lost;
    } vote_state_t;

    vote_state_t s_d, s_q;
    slot_t [HIST_DEPTH-1:0] shifted;
    logic  [HIST_DEPTH-1:0] hit;
    logic  [CODE_W-1:0]     key;
    logic  [CNT_W-1:0]      tally;

    // compare against the held code when valid, else the newest code
    assign key = s_q.valid ? s_q.held : word_code;

    generate
        for (genvar gi = 0; gi < HIST_DEPTH; gi++) begin : g_slot
            if (gi == 0) begin : g_head
                assign shifted[gi] = {word_ok, word_code};
            end else begin : g_tail
                assign shifted[gi] = s_q.hist[gi-1];
            end
            assign hit[gi] = shifted[gi].ok && (shifted[gi].code == key);
        end
    endgenerate

    assign tally = CNT_W'($countones(hit));

    always_comb begin
        s_d      = s_q;
        s_d.lost = 1'b0;
        if (!enable) begin
            s_d = '0;
        end else if (word_stb) begin
            s_d.hist = shifted;
            if (s_q.valid) begin
                if (tally < MIN_C) begin
                    s_d.valid = 1'b0;
                    s_d.held  = '0;
                    s_d.lost  = 1'b1;
                end
            end else if (word_ok && (tally >= MIN_C)) begin
                s_d.valid = 1'b1;
                s_d.held  = word_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_out   = s_q.held;
    assign code_valid = s_q.valid;
    assign msg_lost   = s_q.lost;

endmodule

// File: rtl/bitmsg_rx.sv
// Bit-oriented message receiver: flag search, frame capture, majority vote.
module bitmsg_rx #(
    parameter int CODE_W     = 6,
    parameter int FLAG_LEN   = 8,
    parameter int SYNC_WIN   = 32,
    parameter int HIST_DEPTH = 10,
    parameter int MATCH_MIN  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_valid,
    input  logic              bit_data,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid,
    output logic              msg_lost,
    output logic              sync_fault
);
    logic              flag_hit;
    logic              word_stb;
    logic              word_ok;
    logic [CODE_W-1:0] word_code;

    bitmsg_flag_track #(
        .FLAG_LEN(FLAG_LEN),
        .SYNC_WIN(SYNC_WIN)
    ) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .bit_stb  (bit_valid),
        .bit_data (bit_data),
        .flag_hit (flag_hit),
        .sync_err (sync_fault)
    );

    bitmsg_word_capture #(
        .CODE_W(CODE_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .bit_stb   (bit_valid),
        .bit_data  (bit_data),
        .flag_hit  (flag_hit),
        .word_stb  (word_stb),
        .word_ok   (word_ok),
        .word_code (word_code)
    );

    bitmsg_vote_filter #(
        .CODE_W    (CODE_W),
        .HIST_DEPTH(HIST_DEPTH),
        .MATCH_MIN (MATCH_MIN)
    ) u_vote (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .word_stb   (word_stb),
        .word_ok    (word_ok),
        .word_code  (word_code),
        .code_out   (code_out),
        .code_valid (code_valid),
        .msg_lost   (msg_lost)
    );

endmodule

// File: rtl/bitmsg_rx_checker.sv
// Port-level properties of the receiver, bound into bitmsg_rx.
module bitmsg_rx_checker #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              bit_valid,
    input logic [CODE_W-1:0] code_out,
    input logic              code_valid,
    input logic              msg_lost,
    input logic              sync_fault
);

    assert_zero_when_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |-> (code_out == '0));

    assert_code_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && $past(code_valid)) |-> $stable(code_out));

    assert_lost_marks_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_lost |-> (!code_valid && $past(code_valid)));

    assert_fall_reported_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(code_valid) && $past(enable)) |-> msg_lost);

    assert_lost_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_lost |=> !msg_lost);

    assert_fault_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_fault |=> !sync_fault);

    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (!msg_lost && !sync_fault && !code_valid));

    assert_idle_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bit_valid) && $past(enable)) |->
            ($stable(code_valid) && !msg_lost && !sync_fault));

    assert_rise_on_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> ($past(bit_valid) && $past(enable)));

endmodule

bind bitmsg_rx bitmsg_rx_checker #(.CODE_W(CODE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .bit_valid  (bit_valid),
    .code_out   (code_out),
    .code_valid (code_valid),
    .msg_lost   (msg_lost),
    .sync_fault (sync_fault)
);

// File: tb/bitmsg_rx_tb_top.sv
`timescale 1ns/1ps
module bitmsg_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_data = 1'b0;
    logic [5:0] code_out;
    logic       code_valid;
    logic       msg_lost;
    logic       sync_fault;

    always #5 clk = ~clk;

    bitmsg_rx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .bit_valid  (bit_valid),
        .bit_data   (bit_data),
        .code_out   (code_out),
        .code_valid (code_valid),
        .msg_lost   (msg_lost),
        .sync_fault (sync_fault)
    );

    // ---------------- reference model state ----------------
    int         vectors = 0;
    int         fails   = 0;
    bit         finished = 0;
    string      cur_tag = "R1";

    int         m_run, m_win, m_cnt;
    bit         m_busy;
    bit [7:0]   m_frame;
    int         m_hist[$];     // code value, or -1 for a badly framed frame
    bit         m_valid, m_lost, m_fault;
    int         m_held;

    function automatic int count_code(int c);
        int n = 0;
        foreach (m_hist[i]) if (m_hist[i] == c) n++;
        return n;
    endfunction

    task automatic model_clear();
        m_run = 0; m_win = 0; m_cnt = 0; m_busy = 0; m_frame = '0;
        m_hist.delete();
        m_valid = 0; m_held = 0; m_lost = 0; m_fault = 0;
    endtask

    task automatic model_step(input bit en, input bit bv, input bit b);
        bit flag;
        m_lost = 0; m_fault = 0;
        if (!en) begin
            model_clear();
        end else if (bv) begin
            flag = 0;
            if (b) begin
                if (m_run == 7) begin flag = 1; m_run = 0; end
                else m_run++;
            end else begin
                m_run = 0;
            end
            if (flag) m_win = 0;
            else if (m_win == 31) begin m_win = 0; m_fault = 1; end
            else m_win++;

            if (m_busy) begin
                m_frame = {m_frame[6:0], b};
                m_cnt++;
                if (m_cnt == 8) begin
                    int entry;
                    m_busy = 0;
                    entry = (!m_frame[7] && !m_frame[0]) ? int'(m_frame[6:1]) : -1;
                    m_hist.push_front(entry);
                    if (m_hist.size() > 10) void'(m_hist.pop_back());
                    if (m_valid) begin
                        if (count_code(m_held) < 7) begin
                            m_valid = 0; m_held = 0; m_lost = 1;
                        end
                    end else if (entry >= 0 && count_code(entry) >= 7) begin
                        m_valid = 1; m_held = entry;
                    end
                end
            end else if (flag) begin
                m_busy = 1; m_cnt = 0; m_frame = '0;
            end
        end
    endtask

    task automatic compare();
        vectors++;
        if (code_valid !== m_valid || code_out !== 6'(m_held) ||
            msg_lost !== m_lost || sync_fault !== m_fault) begin
            fails++;
            $display("FAIL %s t=%0t valid=%0b/%0b code=%0d/%0d lost=%0b/%0b fault=%0b/%0b",
                     cur_tag, $time, code_valid, m_valid, code_out, m_held,
                     msg_lost, m_lost, sync_fault, m_fault);
        end
    endtask

    task automatic step(input bit en, input bit bv, input bit b);
        enable = en; bit_valid = bv; bit_data = b;
        @(posedge clk);
        model_step(en, bv, b);
        @(negedge clk);
        compare();
    endtask

    task automatic send_bits(input int n, input bit b);
        for (int i = 0; i < n; i++) step(1, 1, b);
    endtask

    // frame: eight ones, lead zero, code MSB first, tail zero
    task automatic send_word(input int code, input bit good, input int gap);
        send_bits(8, 1'b1);
        for (int i = 0; i < 8; i++) begin
            bit b;
            if (i == 0) b = !good;
            else if (i == 7) b = 1'b0;
            else b = code[6-i];
            for (int g = 0; g < gap; g++) step(1, 0, 1'($urandom));
            step(1, 1, b);
        end
    endtask

    task automatic check_idle(input string tag);
        cur_tag = tag;
        compare();
    endtask

    initial begin
        model_clear();
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        step(0, 0, 0);

        // R2 / R3: six matching frames are not enough, the seventh validates
        cur_tag = "R3";
        for (int k = 0; k < 6; k++) send_word(6'h15, 1, 0);
        cur_tag = "R2";
        send_word(6'h15, 1, 0);
        // R4: other codes while the majority holds
        cur_tag = "R4";
        for (int k = 0; k < 3; k++) send_word(6'h0A, 1, 0);
        // R5: fourth mismatch drops the majority
        cur_tag = "R5";
        send_word(6'h0A, 1, 0);
        send_word(6'h0A, 1, 0);

        // R6: rebuild, then poison with badly framed copies of the same code
        cur_tag = "R6";
        for (int k = 0; k < 10; k++) send_word(6'h2C, 1, 0);
        for (int k = 0; k < 4; k++) send_word(6'h2C, 0, 0);
        for (int k = 0; k < 3; k++) send_word(6'h2C, 1, 0);

        // R9: strobe gaps carrying noise
        cur_tag = "R9";
        for (int k = 0; k < 10; k++) send_word(6'h33, 1, 2);
        for (int k = 0; k < 20; k++) step(1, 0, 1'($urandom));

        // R7: silence trips the sync window
        cur_tag = "R7";
        send_bits(70, 1'b0);
        // R7: flag landing exactly on the 32nd bit suppresses the fault
        send_bits(8, 1'b1);
        send_bits(24, 1'b0);
        send_bits(8, 1'b1);
        send_bits(40, 1'b0);

        // R11: continuous ones
        cur_tag = "R11";
        send_bits(150, 1'b1);

        // R8: drop enable while valid, bits ignored, history cleared
        cur_tag = "R8";
        for (int k = 0; k < 8; k++) send_word(6'h07, 1, 0);
        for (int k = 0; k < 40; k++) step(0, 1, 1'($urandom));
        for (int k = 0; k < 6; k++) send_word(6'h07, 1, 0);
        send_bits(3, 1'b1);
        step(0, 1, 1);
        step(1, 1, 1);
        for (int k = 0; k < 7; k++) send_word(6'h07, 1, 0);

        // R10 and mixed traffic
        cur_tag = "R10";
        for (int k = 0; k < 250; k++) begin
            int r = $urandom_range(0, 19);
            if (r == 0) send_bits($urandom_range(1, 40), 1'b0);
            else if (r == 1) step(1, 0, 1'($urandom));
            else if (r == 2) send_word(6'($urandom), 1, 0);
            else send_word((r < 12) ? 6'h19 : 6'h26, (r != 3), $urandom_range(0, 1));
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            fails++;
            $display("FAIL %s watchdog expired", cur_tag);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule